// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside one memory port and decides whether each AXI exclusive store succeeds. It watches the read and write request channels of that port. Each request presents a valid strobe, a lock flag, a transaction ID and a byte address. An exclusive read reserves the addressed granule for its ID in one of a small, fixed set of slots. An exclusive write is compared with the live slots. A write that matches on both ID and granule is allowed through to memory and answered with EXOKAY. A write that finds no match is blocked and answered with OKAY.

The table has no free-slot search. A new reservation always overwrites the slot under a round-robin pointer, and the pointer moves on after each allocation. With the default of two slots, a third exclusive reader evicts the oldest reservation without any indication, and the later exclusive store from the evicted master then fails. The monitor shares no state with monitors on other ports. Exclusive sequences work only between masters that reach memory through the same port.

Top module: `excl_resv_monitor`

## Requirements
- R1: After reset every slot is empty, the round-robin pointer selects slot 0, `bresp_valid` is low, and an exclusive store from any ID fails.
- R2: An exclusive read whose ID holds no live slot writes its ID and granule (address bits at and above `GRAN_LSB`) into the slot under the pointer, marks that slot live, and advances the pointer by one modulo `NUM_SLOTS`.
- R3: An exclusive read whose ID already holds a live slot replaces that slot's granule in place and leaves the pointer unchanged.
- R4: An exclusive write whose ID and granule match a live slot raises `wr_mem_en` in the same cycle and returns code 2'b01 (EXOKAY). Address bits below `GRAN_LSB` play no part in the match.
- R5: An exclusive write without a matching live slot keeps `wr_mem_en` low, returns code 2'b00 (OKAY), and leaves all slots and the pointer unchanged.
- R6: Every write that reaches memory invalidates every live slot holding its granule, whatever the slot's ID. A successful exclusive store therefore consumes its own reservation, and an overlapping normal write cancels reservations.
- R7: A non-exclusive read changes no state. A non-exclusive write always raises `wr_mem_en` and returns code 2'b00.
- R8: With more exclusive readers than slots, round-robin replacement evicts the oldest allocation. The evicted ID's later exclusive store fails, while the surviving reservations still succeed.
- R9: When a read and a write arrive in the same cycle, both are judged on the slot contents at the start of that cycle. An allocation or in-place update of a slot takes precedence over that slot's invalidation.
- R10: `bresp_valid` is high in exactly the cycle after each write request, and `bresp_code` carries that write's result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_valid | input | 1 | Read request present this cycle |
| rd_req_lock | input | 1 | Read request is exclusive |
| rd_req_id | input | ID_W | Read transaction ID |
| rd_req_addr | input | ADDR_W | Read byte address |
| wr_req_valid | input | 1 | Write request present this cycle |
| wr_req_lock | input | 1 | Write request is exclusive |
| wr_req_id | input | ID_W | Write transaction ID |
| wr_req_addr | input | ADDR_W | Write byte address |
| wr_mem_en | output | 1 | Write may update memory (same cycle as the request) |
| bresp_valid | output | 1 | Write response present |
| bresp_code | output | 2 | Write response: 2'b00 OKAY, 2'b01 EXOKAY |

## Verification
A corrupted slot or pointer stays hidden until the next exclusive store. That store then shows the fault twice. `wr_mem_en` is wrong in the same cycle as the store, and `bresp_code` is wrong one cycle later. A pointer that advances at the wrong moment changes which reservation a later read evicts, so the fault only appears as a wrong verdict several transactions afterwards. The bench therefore runs the eviction and in-place update sequences and follows each with the stores that reveal them. A long random run over a small set of IDs and granules then keeps slot contention high. A reference model compares both outputs on every cycle.

// File: rtl/excl_resv_pkg.sv
package excl_resv_pkg;
  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01
  } bresp_e;
endpackage

// File: rtl/excl_resv_slot.sv
module excl_resv_slot #(
  parameter int ID_W  = 4,
  parameter int TAG_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ID_W-1:0]  load_id,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             clear,
  output logic             valid,
  output logic [ID_W-1:0]  id,
  output logic [TAG_W-1:0] tag
);
  logic             valid_q, valid_d;
  logic [ID_W-1:0]  id_q;
  logic [TAG_W-1:0] tag_q;

  // load overrides clear (R9)
  always_comb begin
    valid_d = valid_q;
    if (load)       valid_d = 1'b1;
    else if (clear) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      id_q  <= load_id;
      tag_q <= load_tag;
    end
  end

  assign valid = valid_q;
  assign id    = id_q;
  assign tag   = tag_q;

  assert_load_records_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (valid && id == $past(load_id) && tag == $past(load_tag)));

  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !load) |=> !valid);

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load) |=> $stable(valid));
endmodule

// File: rtl/excl_rr_ptr.sv
module excl_rr_ptr #(
  parameter int N = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                advance,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] ptr
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (advance) begin
      if (ptr_q == PW'(N - 1)) ptr_d = '0;
      else                     ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr));

  assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(N - 1));
endmodule

// File: rtl/excl_wr_resp.sv
module excl_wr_resp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_seen,
  input  logic       excl_pass,
  output logic       bresp_valid,
  output logic [1:0] bresp_code
);
  import excl_resv_pkg::*;

  logic   valid_q, valid_d;
  bresp_e code_q, code_d;

  always_comb begin
    valid_d = wr_seen;
    code_d  = code_q;
    if (wr_seen) code_d = excl_pass ? RESP_EXOKAY : RESP_OKAY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= RESP_OKAY;
    end else begin
      valid_q <= valid_d;
      code_q  <= code_d;
    end
  end

  assign bresp_valid = valid_q;
  assign bresp_code  = code_q;

  assert_resp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seen |=> bresp_valid);

  assert_resp_only_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bresp_valid |-> $past(wr_seen));

  assert_code_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bresp_valid |-> (bresp_code == 2'b00 || bresp_code == 2'b01));
endmodule

// File: rtl/excl_resv_monitor.sv
module excl_resv_monitor #(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 32,
  parameter int GRAN_LSB  = 3,
  parameter int NUM_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_valid,
  input  logic              rd_req_lock,
  input  logic [ID_W-1:0]   rd_req_id,
  input  logic [ADDR_W-1:0] rd_req_addr,
  input  logic              wr_req_valid,
  input  logic              wr_req_lock,
  input  logic [ID_W-1:0]   wr_req_id,
  input  logic [ADDR_W-1:0] wr_req_addr,
  output logic              wr_mem_en,
  output logic              bresp_valid,
  output logic [1:0]        bresp_code
);
  localparam int TAG_W = ADDR_W - GRAN_LSB;
  localparam int PW    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic             unused_low_bits;
  logic             rd_excl, wr_excl;
  logic             any_rd_id_hit, excl_pass;
  logic [PW-1:0]    ptr;

  logic [NUM_SLOTS-1:0] slot_valid, slot_load, slot_clear;
  logic [NUM_SLOTS-1:0] rd_id_hit, wr_tag_hit, wr_excl_hit;
  logic [ID_W-1:0]      slot_id  [NUM_SLOTS];
  logic [TAG_W-1:0]     slot_tag [NUM_SLOTS];

  assign rd_tag          = rd_req_addr[ADDR_W-1:GRAN_LSB];
  assign wr_tag          = wr_req_addr[ADDR_W-1:GRAN_LSB];
  assign unused_low_bits = ^{rd_req_addr[GRAN_LSB-1:0], wr_req_addr[GRAN_LSB-1:0]};

  assign rd_excl = rd_req_valid && rd_req_lock;
  assign wr_excl = wr_req_valid && wr_req_lock;

  genvar i;
  generate
    for (i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign rd_id_hit[i]   = slot_valid[i] && (slot_id[i] == rd_req_id);
      assign wr_tag_hit[i]  = slot_valid[i] && (slot_tag[i] == wr_tag);
      assign wr_excl_hit[i] = wr_tag_hit[i] && (slot_id[i] == wr_req_id);
      // in-place update for a known ID, else the round-robin victim
      assign slot_load[i]   = rd_excl &&
                              (any_rd_id_hit ? rd_id_hit[i] : (ptr == PW'(i)));
      assign slot_clear[i]  = wr_mem_en && wr_tag_hit[i];

      excl_resv_slot #(
        .ID_W  (ID_W),
        .TAG_W (TAG_W)
      ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (slot_load[i]),
        .load_id  (rd_req_id),
        .load_tag (rd_tag),
        .clear    (slot_clear[i]),
        .valid    (slot_valid[i]),
        .id       (slot_id[i]),
        .tag      (slot_tag[i])
      );
    end
  endgenerate

  assign any_rd_id_hit = |rd_id_hit;
  assign excl_pass     = wr_excl && (|wr_excl_hit);
  assign wr_mem_en     = wr_req_valid && (!wr_req_lock || excl_pass);

  excl_rr_ptr #(
    .N (NUM_SLOTS)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (rd_excl && !any_rd_id_hit),
    .ptr     (ptr)
  );

  excl_wr_resp u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_seen     (wr_req_valid),
    .excl_pass   (excl_pass),
    .bresp_valid (bresp_valid),
    .bresp_code  (bresp_code)
  );

  // one live slot per ID at most (R3)
  generate
    for (i = 0; i < NUM_SLOTS; i++) begin : g_uniq_outer
      for (genvar j = i + 1; j < NUM_SLOTS; j++) begin : g_uniq_inner
        always_comb begin
          if (rst_n) begin
            assert_unique_id_R3: assert (!(slot_valid[i] && slot_valid[j] &&
                                           slot_id[i] == slot_id[j]));
          end
        end
      end
    end
  endgenerate

  assert_exokay_needs_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bresp_valid && bresp_code == 2'b01) |-> $past(wr_req_valid && wr_req_lock && wr_mem_en));

  assert_single_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_load));

  assert_plain_read_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_req_valid && rd_req_lock) && !wr_mem_en) |=> ($stable(slot_valid) && $stable(ptr)));

  assert_failed_store_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bresp_valid && bresp_code == 2'b00 && $past(wr_req_lock)) |-> !$past(wr_mem_en));
endmodule

// File: tb/excl_resv_monitor_tb.sv
module excl_resv_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 2;
  localparam int IDW  = 4;
  localparam int AW   = 32;
  localparam int GL   = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rv, rl, wv, wl;
  logic [IDW-1:0] rid, wid;
  logic [AW-1:0]  ra, wa;
  logic          wr_mem_en, bresp_valid;
  logic [1:0]    bresp_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [1:0] last_code;

  // reference model
  bit       m_valid [NS];
  int       m_id    [NS];
  longint   m_tag   [NS];
  int       m_ptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_resv_monitor #(
    .ID_W(IDW), .ADDR_W(AW), .GRAN_LSB(GL), .NUM_SLOTS(NS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rv), .rd_req_lock(rl), .rd_req_id(rid), .rd_req_addr(ra),
    .wr_req_valid(wv), .wr_req_lock(wl), .wr_req_id(wid), .wr_req_addr(wa),
    .wr_mem_en(wr_mem_en), .bresp_valid(bresp_valid), .bresp_code(bresp_code)
  );

  task automatic check_eq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint tag_of(input logic [AW-1:0] a);
    return longint'(a >> GL);
  endfunction

  // one cycle; entered and left at a falling edge
  task automatic step(input logic irv, input logic irl, input int irid, input logic [AW-1:0] ira,
                      input logic iwv, input logic iwl, input int iwid, input logic [AW-1:0] iwa);
    bit     hit, exp_en;
    int     rd_idx;
    logic [1:0] exp_code;
    string  tag;
    rv = irv; rl = irl; rid = IDW'(irid); ra = ira;
    wv = iwv; wl = iwl; wid = IDW'(iwid); wa = iwa;
    #1;
    hit = 0;
    for (int k = 0; k < NS; k++)
      if (m_valid[k] && m_id[k] == iwid && m_tag[k] == tag_of(iwa)) hit = 1;
    exp_en   = iwv && (!iwl || hit);
    exp_code = (iwv && iwl && hit) ? 2'b01 : 2'b00;
    tag = !iwl ? "R7" : (hit ? "R4" : "R5");
    check_eq({tag, " wr_mem_en"}, longint'(wr_mem_en), longint'(exp_en));
    rd_idx = -1;
    for (int k = 0; k < NS; k++)
      if (rd_idx < 0 && m_valid[k] && m_id[k] == irid) rd_idx = k;
    @(posedge clk);
    if (exp_en)
      for (int k = 0; k < NS; k++)
        if (m_valid[k] && m_tag[k] == tag_of(iwa)) m_valid[k] = 0;
    if (irv && irl) begin
      if (rd_idx < 0) begin
        rd_idx = m_ptr;
        m_ptr  = (m_ptr + 1) % NS;
      end
      m_valid[rd_idx] = 1;
      m_id[rd_idx]    = irid;
      m_tag[rd_idx]   = tag_of(ira);
    end
    @(negedge clk);
    check_eq("R10 bresp_valid", longint'(bresp_valid), longint'(iwv));
    if (iwv) check_eq({tag, " bresp_code"}, longint'(bresp_code), longint'(exp_code));
    last_code = bresp_code;
  endtask

  task automatic xload(input int id, input logic [AW-1:0] a);
    step(1, 1, id, a, 0, 0, 0, 0);
  endtask
  task automatic xstore(input int id, input logic [AW-1:0] a);
    step(0, 0, 0, 0, 1, 1, id, a);
  endtask
  task automatic pstore(input int id, input logic [AW-1:0] a);
    step(0, 0, 0, 0, 1, 0, id, a);
  endtask
  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NS; k++) begin m_valid[k] = 0; m_id[k] = 0; m_tag[k] = 0; end
    m_ptr = 0;
    rst_n = 0; rv = 0; rl = 0; wv = 0; wl = 0; rid = 0; wid = 0; ra = 0; wa = 0;
    repeat (3) @(negedge clk);
    check_eq("R1 bresp_valid in reset", longint'(bresp_valid), 0);
    check_eq("R1 wr_mem_en idle", longint'(wr_mem_en), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: empty table after reset
    xstore(1, 32'h100);
    check_eq("R1 store after reset", longint'(last_code), 0);

    // R8: three readers over two slots
    xload(1, 32'h100);
    xload(2, 32'h200);
    xload(3, 32'h300);
    xstore(1, 32'h100);
    check_eq("R8 evicted store", longint'(last_code), 0);
    xstore(2, 32'h204);
    check_eq("R8 survivor B (R4 low bits ignored)", longint'(last_code), 1);
    xstore(3, 32'h300);
    check_eq("R8 newest C", longint'(last_code), 1);
    xstore(3, 32'h300);
    check_eq("R6 reservation consumed", longint'(last_code), 0);

    // R3: in-place update, pointer unchanged
    xload(4, 32'h400);
    xload(4, 32'h480);
    xload(5, 32'h500);
    xstore(4, 32'h400);
    check_eq("R3 old granule gone", longint'(last_code), 0);
    xstore(4, 32'h480);
    check_eq("R3 updated granule", longint'(last_code), 1);
    xstore(5, 32'h500);
    check_eq("R2 second slot kept", longint'(last_code), 1);

    // R5: ID mismatch fails and leaves reservation intact
    xload(6, 32'h600);
    xstore(7, 32'h600);
    check_eq("R5 wrong ID", longint'(last_code), 0);
    xstore(6, 32'h600);
    check_eq("R5 reservation untouched", longint'(last_code), 1);

    // R6/R7: normal write cancels; plain read allocates nothing
    xload(8, 32'h800);
    pstore(2, 32'h804);
    check_eq("R7 normal write OKAY", longint'(last_code), 0);
    xstore(8, 32'h800);
    check_eq("R6 cancelled by normal write", longint'(last_code), 0);
    step(1, 0, 9, 32'h900, 0, 0, 0, 0);
    xstore(9, 32'h900);
    check_eq("R7 plain read no slot", longint'(last_code), 0);

    // R9: same-cycle load and clearing store on one granule
    xload(10, 32'hA00);
    step(1, 1, 10, 32'hA00, 1, 1, 10, 32'hA00);
    check_eq("R9 store sees start state", longint'(last_code), 1);
    xstore(10, 32'hA00);
    check_eq("R9 reload wins over clear", longint'(last_code), 1);

    // random contention over small ID and granule sets
    for (int n = 0; n < 600; n++) begin
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
           AW'($urandom_range(0, 31)),
           $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
           AW'($urandom_range(0, 31)));
    end
    idle();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule